// File: doc/BRIEF.md
# Multi-source interrupt concentrator with periodic timers

This block gathers three kinds of interrupt events and presents them as a small set of output interrupt lines. The first kind comes from a bank of periodic down-counting timers. The second comes from level-sensitive hardware request inputs, which are resampled on every clock. The third is software interrupts: a bus write to a slot stores a data word and raises that slot's request. Every output line has its own mask for each of the three classes. A line is raised while any unmasked request of any class is pending.

Software runs the block through a simple synchronous register port. The port has a byte address, write data, byte enables, read and write strobes, a ready flag and an error flag. A small bus state machine accepts one access in state `ST_IDLE` and moves to `ST_RESP`. It stays there for exactly one cycle, with ready, read data and error valid, and then goes back to `ST_IDLE`. Reading a software slot returns its word and clears its request. Reading a timer acknowledge register returns the timer's count and clears its request. A priority register tells a handler which classes are pending on its line and the lowest pending slot of each. A bank of general configuration words drives dedicated parallel outputs.

Top module: `irq_concentrator`

## Requirements
- R1: The word cell is the byte address divided by 4. The slot index is cell bits [4:0] and the function code is cell bits [9:5]. The function codes are: 0 software word, 1 timer period, 2 timer count, 3 timer acknowledge, 4/5/6 timer mask set/OR/AND-NOT, 7/8/9 hardware mask set/OR/AND-NOT, 10/11/12 software mask set/OR/AND-NOT, 13 priority, 17 configuration word.
- R2: A write whose byte enables are not all set (4'hF) changes no register and responds with the error flag set.
- R3: An access strobed while the state is `ST_IDLE` moves the state to `ST_RESP` after that clock edge. `bus_ready` is then high for exactly one cycle, with `bus_rdata` and `bus_err` valid. The transition back to `ST_IDLE` is unconditional. If both strobes are high, the write is taken.
- R4: Writing a timer period of zero clears that timer's pending bit and count. Writing a nonzero period loads the count with the period only if the count is zero at that edge.
- R5: On every clock, a timer whose period is nonzero decrements its count. When the count steps from 1 to 0, the timer sets its pending bit and reloads the period, so a period P written onto a zero count sets the pending bit P edges after the write edge.
- R6: A read of timer acknowledge slot i returns timer i's count and clears its pending bit. A timer that expires in the same cycle keeps its pending bit set.
- R7: A write to software slot i stores the word and sets pending bit i. A read returns the stored word and clears pending bit i.
- R8: The hardware pending vector equals `hw_in` as sampled at the previous clock edge.
- R9: `irq_out[l]` is high exactly when (timer mask[l] & timer pending), (hardware mask[l] & hardware pending) or (software mask[l] & software pending) is nonzero.
- R10: A set code replaces a mask, an OR code adds the written bits, and an AND-NOT code removes them. Reading any of the three codes returns the mask.
- R11: A priority read for line l returns: bit 0 if any masked timer is pending, bit 1 for hardware, bit 2 for software. It also returns the lowest masked pending index of each class: timer in [12:8], hardware in [20:16], software in [28:24]. All other bits are zero.
- R12: Configuration word i (code 17) is readable and writable, and drives `cfg_out[32*i +: 32]` continuously.
- R13: An index at or beyond the configured count for its function, an unknown function code, or a write to code 3 or 13 responds with the error flag set and changes no state.
- R14: Reset clears all periods, counts, software words, masks, configuration words and the three pending vectors, and puts the bus state machine in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; writes need all four |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | Response valid for one cycle |
| bus_err | output | 1 | Access refused, valid with ready |
| hw_in | input | N_HWI | Level-sensitive hardware requests |
| irq_out | output | N_OUT | Output interrupt lines |
| cfg_out | output | 32*N_CFG | Configuration words, word i at bits [32*i +: 32] |

## Verification
A register write or a clearing read takes effect at the edge that samples the strobe. Its effect on `irq_out`, `cfg_out` and the response arrives one cycle later. A hardware input reaches `irq_out` one edge after it changes. A timer with period P raises its request P edges after the edge that wrote the period. The bench drives every stimulus at a falling edge and samples one falling edge after the edge that accepts it. It counts clock edges explicitly around timer expiry, so each expected value is compared in the first cycle it is due and not earlier.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int FW = 5;
    localparam int IW = 5;

    typedef enum logic [4:0] {
        F_SWI  = 5'd0,  F_TPER = 5'd1,  F_TCNT = 5'd2,  F_TACK = 5'd3,
        F_TMSK = 5'd4,  F_TMEN = 5'd5,  F_TMDI = 5'd6,
        F_HMSK = 5'd7,  F_HMEN = 5'd8,  F_HMDI = 5'd9,
        F_SMSK = 5'd10, F_SMEN = 5'd11, F_SMDI = 5'd12,
        F_PRIO = 5'd13, F_CFG  = 5'd17
    } func_e;

    typedef enum logic {ST_IDLE, ST_RESP} bus_st_e;

    // lowest set bit position, zero when none
    function automatic logic [IW-1:0] low_idx(input logic [DW-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int b = DW-1; b >= 0; b--)
            if (v[b]) r = IW'(b);
        return r;
    endfunction
endpackage

// File: rtl/irqc_bus_fsm.sv
`timescale 1ns/1ps
module irqc_bus_fsm
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          wr,
    input  logic          be_full,
    input  logic [DW-1:0] rdata_in,
    input  logic          err_in,
    output logic          do_rd,
    output logic          do_wr,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          err
);
    bus_st_e st, st_nx;
    logic    take;

    assign take  = (st == ST_IDLE) && (rd || wr);
    assign do_wr = (st == ST_IDLE) && wr && be_full;
    assign do_rd = (st == ST_IDLE) && rd && !wr;
    assign ready = (st == ST_RESP);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (rd || wr) st_nx = ST_RESP;
            ST_RESP: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else if (take) begin
            rdata <= do_rd ? rdata_in : '0;
            err   <= err_in || (wr && !be_full);
        end
    end

    // R3
    ready_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R3
    ready_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ready);
endmodule

// File: rtl/irqc_timer_bank.sv
`timescale 1ns/1ps
module irqc_timer_bank
    import irqc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_per,
    input  logic                  wr_cnt,
    input  logic                  ack,
    input  logic [IW-1:0]         idx,
    input  logic [DW-1:0]         wdata,
    output logic [N-1:0][DW-1:0]  per_q,
    output logic [N-1:0][DW-1:0]  cnt_q,
    output logic [N-1:0]          pend
);
    for (genvar i = 0; i < N; i++) begin : g_tmr
        logic sel;
        assign sel = (idx == IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_q[i] <= '0;
                cnt_q[i] <= '0;
                pend[i]  <= 1'b0;
            end else begin
                if (ack && sel) pend[i] <= 1'b0;
                if (per_q[i] != '0) begin
                    if (cnt_q[i] == DW'(1)) begin
                        pend[i]  <= 1'b1;
                        cnt_q[i] <= per_q[i];
                    end else begin
                        cnt_q[i] <= cnt_q[i] - DW'(1);
                    end
                end
                if (wr_per && sel) begin
                    per_q[i] <= wdata;
                    if (wdata == '0) begin
                        pend[i]  <= 1'b0;
                        cnt_q[i] <= '0;
                    end else if (cnt_q[i] == '0) begin
                        cnt_q[i] <= wdata;
                    end
                end
                if (wr_cnt && sel) cnt_q[i] <= wdata;
            end
        end

        // R4
        zero_period_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_per && sel && wdata == '0) |=> (cnt_q[i] == '0 && !pend[i]));
        // R5
        tick_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(sel && (wr_per || wr_cnt)) && per_q[i] != '0 && cnt_q[i] > DW'(1))
            |=> cnt_q[i] == $past(cnt_q[i]) - DW'(1));
        // R5
        expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(sel && (wr_per || wr_cnt)) && per_q[i] != '0 && cnt_q[i] == DW'(1))
            |=> (pend[i] && cnt_q[i] == $past(per_q[i])));
    end
endmodule

// File: rtl/irqc_line.sv
`timescale 1ns/1ps
module irqc_line
    import irqc_pkg::*;
#(
    parameter int NT = 4,
    parameter int NH = 6,
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          hit,
    input  logic [FW-1:0] func,
    input  logic [NT-1:0] wd_t,
    input  logic [NH-1:0] wd_h,
    input  logic [NS-1:0] wd_s,
    input  logic [NT-1:0] tpend,
    input  logic [NH-1:0] hpend,
    input  logic [NS-1:0] spend,
    output logic [NT-1:0] tmsk,
    output logic [NH-1:0] hmsk,
    output logic [NS-1:0] smsk,
    output logic          irq,
    output logic [DW-1:0] prio
);
    logic [NT-1:0] ta;
    logic [NH-1:0] ha;
    logic [NS-1:0] sa;
    logic          we;

    assign we = wr && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmsk <= '0;
            hmsk <= '0;
            smsk <= '0;
        end else if (we) begin
            case (func)
                F_TMSK:  tmsk <= wd_t;
                F_TMEN:  tmsk <= tmsk | wd_t;
                F_TMDI:  tmsk <= tmsk & ~wd_t;
                F_HMSK:  hmsk <= wd_h;
                F_HMEN:  hmsk <= hmsk | wd_h;
                F_HMDI:  hmsk <= hmsk & ~wd_h;
                F_SMSK:  smsk <= wd_s;
                F_SMEN:  smsk <= smsk | wd_s;
                F_SMDI:  smsk <= smsk & ~wd_s;
                default: ;
            endcase
        end
    end

    always_comb begin
        ta   = tmsk & tpend;
        ha   = hmsk & hpend;
        sa   = smsk & spend;
        irq  = (|ta) || (|ha) || (|sa);
        prio = '0;
        prio[0]     = |ta;
        prio[1]     = |ha;
        prio[2]     = |sa;
        prio[12:8]  = low_idx(DW'(ta));
        prio[20:16] = low_idx(DW'(ha));
        prio[28:24] = low_idx(DW'(sa));
    end

    // R10
    mask_or_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && func == F_SMEN) |=> ((smsk & $past(wd_s)) == $past(wd_s)));
    // R10
    mask_andn_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && func == F_HMDI) |=> ((hmsk & $past(wd_h)) == '0));
    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmsk == '0 && hmsk == '0 && smsk == '0) |-> !irq);
endmodule

// File: rtl/irq_concentrator.sv
`timescale 1ns/1ps
module irq_concentrator
    import irqc_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int N_HWI = 6,
    parameter int N_SWI = 4,
    parameter int N_OUT = 2,
    parameter int N_CFG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic [3:0]          bus_be,
    input  logic                bus_rd,
    input  logic                bus_wr,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_ready,
    output logic                bus_err,
    input  logic [N_HWI-1:0]    hw_in,
    output logic [N_OUT-1:0]    irq_out,
    output logic [N_CFG*DW-1:0] cfg_out
);
    logic [FW-1:0] func;
    logic [IW-1:0] idx;
    logic [1:0]    unused_lsb;
    logic [IW:0]   lim;
    logic          ro, in_rng, err_in, do_rd, do_wr, acc_rd, acc_wr;
    logic [DW-1:0] rd_val;

    logic [N_SWI-1:0][DW-1:0] swi_word;
    logic [N_SWI-1:0]         swi_pend;
    logic [N_CFG-1:0][DW-1:0] cfg_q;
    logic [N_HWI-1:0]         hw_pend;
    logic [N_TMR-1:0][DW-1:0] per_q, cnt_q;
    logic [N_TMR-1:0]         tmr_pend;
    logic [N_OUT-1:0][N_TMR-1:0] tmsk_all;
    logic [N_OUT-1:0][N_HWI-1:0] hmsk_all;
    logic [N_OUT-1:0][N_SWI-1:0] smsk_all;
    logic [N_OUT-1:0][DW-1:0]    prio_all;

    assign func       = bus_addr[AW-1 -: FW];
    assign idx        = bus_addr[2 +: IW];
    assign unused_lsb = bus_addr[1:0];

    always_comb begin
        lim = '0;
        ro  = 1'b0;
        case (func)
            F_SWI:                  lim = (IW+1)'(N_SWI);
            F_TPER, F_TCNT:         lim = (IW+1)'(N_TMR);
            F_TACK:    begin        lim = (IW+1)'(N_TMR); ro = 1'b1; end
            F_TMSK, F_TMEN, F_TMDI,
            F_HMSK, F_HMEN, F_HMDI,
            F_SMSK, F_SMEN, F_SMDI: lim = (IW+1)'(N_OUT);
            F_PRIO:    begin        lim = (IW+1)'(N_OUT); ro = 1'b1; end
            F_CFG:                  lim = (IW+1)'(N_CFG);
            default:                lim = '0;
        endcase
    end

    assign in_rng = ({1'b0, idx} < lim);
    assign err_in = !in_rng || (bus_wr && ro);
    assign acc_wr = do_wr && in_rng && !ro;
    assign acc_rd = do_rd && in_rng;

    irqc_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .be_full(&bus_be),
        .rdata_in(rd_val), .err_in(err_in), .do_rd(do_rd), .do_wr(do_wr),
        .ready(bus_ready), .rdata(bus_rdata), .err(bus_err)
    );

    irqc_timer_bank #(.N(N_TMR)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .wr_per(acc_wr && func == F_TPER), .wr_cnt(acc_wr && func == F_TCNT),
        .ack(acc_rd && func == F_TACK), .idx(idx), .wdata(bus_wdata),
        .per_q(per_q), .cnt_q(cnt_q), .pend(tmr_pend)
    );

    for (genvar l = 0; l < N_OUT; l++) begin : g_line
        irqc_line #(.NT(N_TMR), .NH(N_HWI), .NS(N_SWI)) u_line (
            .clk(clk), .rst_n(rst_n), .wr(acc_wr), .hit(idx == IW'(l)), .func(func),
            .wd_t(bus_wdata[N_TMR-1:0]), .wd_h(bus_wdata[N_HWI-1:0]),
            .wd_s(bus_wdata[N_SWI-1:0]),
            .tpend(tmr_pend), .hpend(hw_pend), .spend(swi_pend),
            .tmsk(tmsk_all[l]), .hmsk(hmsk_all[l]), .smsk(smsk_all[l]),
            .irq(irq_out[l]), .prio(prio_all[l])
        );
    end

    for (genvar s = 0; s < N_SWI; s++) begin : g_swi
        logic hit;
        assign hit = (func == F_SWI) && (idx == IW'(s));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                swi_word[s] <= '0;
                swi_pend[s] <= 1'b0;
            end else if (acc_wr && hit) begin
                swi_word[s] <= bus_wdata;
                swi_pend[s] <= 1'b1;
            end else if (acc_rd && hit) begin
                swi_pend[s] <= 1'b0;
            end
        end
        // R7
        swi_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_wr && hit) |=> swi_pend[s]);
        // R7
        swi_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_rd && hit) |=> !swi_pend[s]);
    end

    for (genvar c = 0; c < N_CFG; c++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        cfg_q[c] <= '0;
            else if (acc_wr && func == F_CFG && idx == IW'(c)) cfg_q[c] <= bus_wdata;
        end
    end
    assign cfg_out = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hw_pend <= '0;
        else        hw_pend <= hw_in;
    end

    always_comb begin
        rd_val = '0;
        case (func)
            F_SWI:  for (int k = 0; k < N_SWI; k++) if (idx == IW'(k)) rd_val = swi_word[k];
            F_TPER: for (int k = 0; k < N_TMR; k++) if (idx == IW'(k)) rd_val = per_q[k];
            F_TCNT, F_TACK:
                    for (int k = 0; k < N_TMR; k++) if (idx == IW'(k)) rd_val = cnt_q[k];
            F_TMSK, F_TMEN, F_TMDI:
                    for (int k = 0; k < N_OUT; k++) if (idx == IW'(k)) rd_val = DW'(tmsk_all[k]);
            F_HMSK, F_HMEN, F_HMDI:
                    for (int k = 0; k < N_OUT; k++) if (idx == IW'(k)) rd_val = DW'(hmsk_all[k]);
            F_SMSK, F_SMEN, F_SMDI:
                    for (int k = 0; k < N_OUT; k++) if (idx == IW'(k)) rd_val = DW'(smsk_all[k]);
            F_PRIO: for (int k = 0; k < N_OUT; k++) if (idx == IW'(k)) rd_val = prio_all[k];
            F_CFG:  for (int k = 0; k < N_CFG; k++) if (idx == IW'(k)) rd_val = cfg_q[k];
            default: rd_val = '0;
        endcase
    end

    // R8
    hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hw_pend == $past(hw_in));
    // R13
    refused_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && !in_rng) |=> ($stable(cfg_q) && $stable(swi_word)));
    // R2
    partial_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(&bus_be) && !bus_ready) |=> ($stable(cfg_q) && $stable(swi_word) && bus_err));
endmodule

// File: tb/irq_concentrator_bench.sv
`timescale 1ns/1ps
module irq_concentrator_bench;
    localparam int NT = 4, NH = 6, NS = 4, NO = 2, NC = 2;
    localparam logic [4:0] C_SWI = 5'd0, C_TPER = 5'd1, C_TCNT = 5'd2, C_TACK = 5'd3,
                           C_TMSK = 5'd4, C_HMSK = 5'd7, C_HMEN = 5'd8,
                           C_SMSK = 5'd10, C_SMEN = 5'd11, C_SMDI = 5'd12,
                           C_PRIO = 5'd13, C_CFG = 5'd17;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [11:0]   b_addr = '0;
    logic [31:0]   b_wdata = '0;
    logic [3:0]    b_be = 4'hF;
    logic          b_rd = 1'b0, b_wr = 1'b0;
    logic [31:0]   bus_rdata;
    logic          bus_ready, bus_err;
    logic [NH-1:0] hw_in = '0;
    logic [NO-1:0] irq_out;
    logic [NC*32-1:0] cfg_out;

    int n_chk = 0, n_fail = 0;
    logic          last_rdy, last_err;
    logic [31:0]   rdv;

    // reference model of the randomly exercised state
    logic [31:0]   m_sw_word [NS];
    logic [NS-1:0] m_sp;
    logic [NH-1:0] m_hp;
    logic [NS-1:0] m_sm [NO];
    logic [NH-1:0] m_hm [NO];

    always #2.5 clk = ~clk;

    irq_concentrator #(.N_TMR(NT), .N_HWI(NH), .N_SWI(NS), .N_OUT(NO), .N_CFG(NC))
    u_irq_concentrator (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_be(b_be),
        .bus_rd(b_rd), .bus_wr(b_wr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .hw_in(hw_in), .irq_out(irq_out), .cfg_out(cfg_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_w(input logic [4:0] f, input logic [4:0] i, input logic [31:0] d,
                         input logic [3:0] be = 4'hF);
        @(negedge clk);
        b_addr = {f, i, 2'b00}; b_wdata = d; b_be = be; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0; b_be = 4'hF;
        last_rdy = bus_ready; last_err = bus_err;
    endtask

    task automatic bus_r(input logic [4:0] f, input logic [4:0] i, output logic [31:0] d);
        @(negedge clk);
        b_addr = {f, i, 2'b00}; b_rd = 1'b1;
        @(negedge clk);
        b_rd = 1'b0;
        d = bus_rdata; last_rdy = bus_ready; last_err = bus_err;
    endtask

    function automatic logic [4:0] low_of(input logic [31:0] v);
        logic [4:0] r = 5'd0;
        for (int b = 31; b >= 0; b--) if (v[b]) r = 5'(b);
        return r;
    endfunction

    function automatic logic [31:0] exp_prio(input int l);
        logic [31:0] ha = 32'(m_hm[l] & m_hp);
        logic [31:0] sa = 32'(m_sm[l] & m_sp);
        logic [31:0] r = '0;
        r[1] = |ha; r[2] = |sa;
        r[20:16] = low_of(ha);
        r[28:24] = low_of(sa);
        return r;
    endfunction

    function automatic logic [NO-1:0] exp_irq();
        logic [NO-1:0] r;
        for (int l = 0; l < NO; l++) r[l] = |(m_hm[l] & m_hp) || |(m_sm[l] & m_sp);
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R14 reset state
        check("R14 irq", 32'(irq_out), 0);
        check("R14 cfg", cfg_out[31:0] | cfg_out[63:32], 0);
        check("R14 ready", 32'(bus_ready), 0);
        rst_n = 1'b1;
        bus_r(C_TPER, 5'd1, rdv);  check("R14 period", rdv, 0);
        bus_r(C_SMSK, 5'd0, rdv);  check("R14 mask", rdv, 0);

        // R3 handshake: ready for one cycle only
        check("R3 ready", 32'(last_rdy), 1);
        @(negedge clk); check("R3 ready drop", 32'(bus_ready), 0);

        // R12 R1 configuration words on code 17
        bus_w(C_CFG, 5'd1, 32'hA5A5_1234);
        check("R12 cfg out1", cfg_out[63:32], 32'hA5A5_1234);
        check("R12 cfg out0", cfg_out[31:0], 0);
        bus_r(C_CFG, 5'd1, rdv); check("R1 cfg readback", rdv, 32'hA5A5_1234);

        // R2 partial byte enables
        bus_w(C_CFG, 5'd0, 32'hFFFF_FFFF, 4'h3);
        check("R2 err", 32'(last_err), 1);
        check("R2 cfg unchanged", cfg_out[31:0], 0);

        // R13 refused accesses
        bus_w(C_CFG, 5'd2, 32'h1111_1111);
        check("R13 cfg range err", 32'(last_err), 1);
        check("R13 cfg unchanged", cfg_out[63:32], 32'hA5A5_1234);
        bus_r(5'd20, 5'd0, rdv);    check("R13 unknown err", 32'(last_err), 1);
        bus_r(C_SWI, 5'd4, rdv);    check("R13 swi range err", 32'(last_err), 1);
        bus_w(C_PRIO, 5'd0, 32'h7); check("R13 ro err", 32'(last_err), 1);

        // R7 R9 R11 software interrupts
        bus_w(C_SMSK, 5'd0, 32'h2);
        check("R9 idle", 32'(irq_out), 0);
        bus_w(C_SWI, 5'd1, 32'h0000_DEAD);
        check("R9 sw raise", 32'(irq_out), 32'h1);
        bus_r(C_PRIO, 5'd0, rdv); check("R11 prio sw", rdv, 32'h0100_0004);
        bus_r(C_SWI, 5'd1, rdv);  check("R7 sw word", rdv, 32'h0000_DEAD);
        check("R7 sw cleared", 32'(irq_out), 0);

        // R10 mask OR / AND-NOT
        bus_w(C_SMEN, 5'd1, 32'h5);
        bus_w(C_SMDI, 5'd1, 32'h1);
        bus_r(C_SMEN, 5'd1, rdv); check("R10 mask ops", rdv, 32'h4);

        // R8 hardware level input, one edge of latency
        bus_w(C_HMSK, 5'd1, 32'h20);
        @(negedge clk); hw_in = 6'h20;
        check("R8 not yet", 32'(irq_out), 0);
        @(negedge clk); check("R8 raised", 32'(irq_out), 32'h2);
        hw_in = '0;
        @(negedge clk); check("R8 dropped", 32'(irq_out), 0);

        // R5 R6 timer expiry after P edges, acknowledge read
        bus_w(C_TMSK, 5'd0, 32'h4);
        bus_w(C_TPER, 5'd2, 32'd5);
        repeat (4) @(posedge clk);
        @(negedge clk); check("R5 before expiry", 32'(irq_out), 0);
        @(posedge clk);
        @(negedge clk); check("R5 expiry", 32'(irq_out), 32'h1);
        bus_r(C_TACK, 5'd2, rdv);
        check("R6 ack count", rdv, 32'd4);
        check("R6 ack clears", 32'(irq_out), 0);
        // R4 zero period
        bus_w(C_TPER, 5'd2, 32'd0);
        bus_r(C_TCNT, 5'd2, rdv); check("R4 zero count", rdv, 0);
        // R4 nonzero period onto nonzero count keeps count
        bus_w(C_TCNT, 5'd3, 32'd100);
        bus_w(C_TPER, 5'd3, 32'd7);
        bus_r(C_TCNT, 5'd3, rdv); check("R4 count kept", rdv, 32'd99);
        bus_w(C_TPER, 5'd3, 32'd0);
        bus_w(C_TMSK, 5'd0, 32'h0);

        // random traffic against the model (R7 R9 R10 R11)
        for (int s = 0; s < NS; s++) m_sw_word[s] = (s == 1) ? 32'h0000_DEAD : 32'h0;
        m_sp = '0; m_hp = '0;
        m_sm[0] = 4'h2; m_sm[1] = 4'h4;
        m_hm[0] = '0;   m_hm[1] = 6'h20;
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 5);
            int s  = $urandom_range(0, NS-1);
            int l  = $urandom_range(0, NO-1);
            logic [31:0] d = $urandom;
            case (op)
                0: begin bus_w(C_SWI, 5'(s), d); m_sw_word[s] = d; m_sp[s] = 1'b1; end
                1: begin
                    bus_r(C_SWI, 5'(s), rdv);
                    check("R7 random word", rdv, m_sw_word[s]);
                    m_sp[s] = 1'b0;
                end
                2: begin
                    int k = $urandom_range(0, 2);
                    bus_w(C_SMSK + 5'(k), 5'(l), d);
                    if (k == 0)      m_sm[l] = d[NS-1:0];
                    else if (k == 1) m_sm[l] = m_sm[l] | d[NS-1:0];
                    else             m_sm[l] = m_sm[l] & ~d[NS-1:0];
                end
                3: begin
                    @(negedge clk); hw_in = d[NH-1:0];
                    @(negedge clk); m_hp = d[NH-1:0];
                end
                4: begin bus_w(C_HMEN, 5'(l), d); m_hm[l] = m_hm[l] | d[NH-1:0]; end
                default: begin
                    bus_r(C_PRIO, 5'(l), rdv);
                    check("R11 random prio", rdv, exp_prio(l));
                end
            endcase
            check("R9 random irq", 32'(irq_out), 32'(exp_irq()));
            if (op == 4 && (it % 7) == 0) bus_w(C_HMSK, 5'(l), 32'h0);
            if (op == 4 && (it % 7) == 0) m_hm[l] = '0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule